// File: doc/BRIEF.md
# Digital PWM Generator with Adaptive Dead Time

This block drives the high-side and low-side switch commands of a synchronous buck stage. A period counter runs at one of three selectable lengths and forms a digital sawtooth. At each period boundary a set/reset flop is set when the duty command is non-zero. It is cleared when the count reaches the on-time. The on-time is the duty command, limited to about 95% of the period.

The two gate commands are sequenced by a small state machine that waits on feedback instead of fixed delays. The low-side command rises only after the switch node is reported low, or after a programmable timeout if that report never comes. The high-side command rises only after the low-side gate is reported low. When the enable from the power sequencer is low, both commands are held low. After enable, the low side stays off until the first high-side pulse, so the stage cannot sink current from a pre-biased output.

Top module: `pwm_adaptive_dt`

## Requirements
- R1: During reset, and while `en_i` is low, `hdrv_o` and `ldrv_o` are both low.
- R2: The period is 166, 83 or 50 clocks for `freq_sel_i` equal to 0, 1 or 2; the value 3 selects 50 clocks. A new selection takes effect at the next period boundary. The first period after reset is 166 clocks.
- R3: The PWM request is high for the first N counts of a period. N is `duty_i` sampled in the last clock of the previous period, after the clamp of R4. Lowering N by one shortens the high-side pulse by one clock.
- R4: N is never larger than P - floor(P/20), where P is the period in clocks. A command above that limit gives the same high-side pulse width as a command equal to the limit.
- R5: A duty command of zero keeps `hdrv_o` low for the whole period while the low side stays on.
- R6: `ldrv_o` rises only after a clock in which `hdrv_o` was low. With `sw_low_i` reported in the first clock after the high side turns off, both commands are low for exactly one clock; a report after k clocks gives k clocks.
- R7: `hdrv_o` rises only in the clock after `lg_low_i` was high and `ldrv_o` was low. With immediate feedback, the gap from `ldrv_o` falling to `hdrv_o` rising is one clock.
- R8: If `sw_low_i` never arrives, `ldrv_o` rises after max(1, `sw_tmo_i`) clocks with both commands low.
- R9: `hdrv_o` and `ldrv_o` are never high in the same clock.
- R10: One clock after `en_i` is sampled low, both commands are low. After enable, `ldrv_o` stays low until the first high-side pulse has occurred.
- R11: If the PWM request ends while the high side is still waiting for `lg_low_i`, the low side turns back on and the high side is skipped for that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver enable from the power sequencer |
| freq_sel_i | input | 2 | Period select (0: 166, 1: 83, 2 and 3: 50 clocks) |
| duty_i | input | DUTY_W (8) | On-time command in clocks |
| sw_tmo_i | input | TMO_W (8) | Switch-node timeout in clocks |
| sw_low_i | input | 1 | Switch node is below threshold (synchronous) |
| lg_low_i | input | 1 | Low-side gate is below threshold (synchronous) |
| hdrv_o | output | 1 | High-side switch command |
| ldrv_o | output | 1 | Low-side switch command |

## Verification
The hardest states to reach from the ports are the fallback paths. One is the forced low-side turn-on when the switch node never reports low. The other is the PWM request ending while the high side is still waiting for the low-side gate. A healthy power stage never produces either. The bench therefore drives the two feedback flags from a small behavioural power-stage model, which has a settable switch-node delay and can hold either flag stuck. Stuck and delayed feedback are applied at several timeout settings. Gap widths are measured in clocks between the edges of the two commands.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // both off, awaiting first high-side request
    ST_HS   = 3'd1,  // high side on
    ST_WSW  = 3'd2,  // both off, awaiting switch node low
    ST_LS   = 3'd3,  // low side on
    ST_WLG  = 3'd4   // both off, awaiting low-side gate low
  } dt_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pwm_dt_period.sv
module pwm_dt_period #(
  parameter int unsigned PER_0  = 166,
  parameter int unsigned PER_1  = 83,
  parameter int unsigned PER_2  = 50,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        freq_sel_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int unsigned PER_MAX = pwm_dt_pkg::max3(PER_0, PER_1, PER_2);
  localparam int unsigned CNT_W   = $clog2(PER_MAX + 1);
  localparam int unsigned CMP_W   = ((CNT_W > DUTY_W) ? CNT_W : DUTY_W) + 1;

  logic [CNT_W-1:0] last_tab  [4];
  logic [CNT_W-1:0] clamp_tab [4];

  // select codes 2 and 3 share the fastest period
  for (genvar g = 0; g < 4; g++) begin : g_tab
    localparam int unsigned PER = (g == 0) ? PER_0 : (g == 1) ? PER_1 : PER_2;
    assign last_tab[g]  = CNT_W'(PER - 1);
    assign clamp_tab[g] = CNT_W'(PER - PER / 20);
  end

  logic [CNT_W-1:0] cnt_q, last_q, on_q;
  logic [CNT_W-1:0] last_sel, clamp_sel, on_nxt, cnt_inc;
  logic [CMP_W-1:0] duty_ext, clamp_ext;
  logic             wrap;

  always_comb begin
    last_sel  = last_tab[freq_sel_i];
    clamp_sel = clamp_tab[freq_sel_i];
    duty_ext  = CMP_W'(duty_i);
    clamp_ext = CMP_W'(clamp_sel);
    on_nxt    = (duty_ext > clamp_ext) ? clamp_sel : CNT_W'(duty_i);
    cnt_inc   = cnt_q + 1'b1;
    wrap      = (cnt_q == last_q);
  end

  // period length and on-time are taken only at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= CNT_W'(PER_0 - 1);
      on_q   <= '0;
      pwm_o  <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      last_q <= last_sel;
      on_q   <= on_nxt;
      pwm_o  <= (on_nxt != '0);
    end else begin
      cnt_q <= cnt_inc;
      if (cnt_inc == on_q) pwm_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_dt_tmo.sv
module pwm_dt_tmo #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] tmr_q;

  // loads 1 on entry so the first waiting clock already counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tmr_q <= '0;
    else if (clr_i)                   tmr_q <= TMO_W'(1);
    else if (run_i && (tmr_q != '1))  tmr_q <= tmr_q + 1'b1;
  end

  assign expired_o = (tmr_q >= limit_i);

endmodule

// File: rtl/pwm_dt_fsm.sv
module pwm_dt_fsm
  import pwm_dt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic lg_low_i,
  input  logic expired_i,
  output logic wait_enter_o,
  output logic wait_run_o,
  output logic hdrv_o,
  output logic ldrv_o
);
  dt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: if (pwm_i && lg_low_i)          st_d = ST_HS;
        ST_HS:  if (!pwm_i)                     st_d = ST_WSW;
        ST_WSW: if (sw_low_i || expired_i)      st_d = ST_LS;
        ST_LS:  if (pwm_i)                      st_d = ST_WLG;
        ST_WLG: begin
          if (!pwm_i)        st_d = ST_LS;   // request gone: skip this pulse
          else if (lg_low_i) st_d = ST_HS;
        end
        default:                                st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign wait_enter_o = (st_d == ST_WSW) && (st_q != ST_WSW);
  assign wait_run_o   = (st_q == ST_WSW);
  assign hdrv_o       = (st_q == ST_HS);
  assign ldrv_o       = (st_q == ST_LS);

endmodule

// File: rtl/pwm_adaptive_dt.sv
module pwm_adaptive_dt #(
  parameter int unsigned PER_0  = 166,
  parameter int unsigned PER_1  = 83,
  parameter int unsigned PER_2  = 50,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned TMO_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        freq_sel_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [TMO_W-1:0]  sw_tmo_i,
  input  logic              sw_low_i,
  input  logic              lg_low_i,
  output logic              hdrv_o,
  output logic              ldrv_o
);
  logic pwm, expired, wait_enter, wait_run;

  pwm_dt_period #(
    .PER_0 (PER_0),
    .PER_1 (PER_1),
    .PER_2 (PER_2),
    .DUTY_W(DUTY_W)
  ) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .freq_sel_i(freq_sel_i),
    .duty_i    (duty_i),
    .pwm_o     (pwm)
  );

  pwm_dt_tmo #(
    .TMO_W(TMO_W)
  ) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wait_enter),
    .run_i    (wait_run),
    .limit_i  (sw_tmo_i),
    .expired_o(expired)
  );

  pwm_dt_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .pwm_i       (pwm),
    .sw_low_i    (sw_low_i),
    .lg_low_i    (lg_low_i),
    .expired_i   (expired),
    .wait_enter_o(wait_enter),
    .wait_run_o  (wait_run),
    .hdrv_o      (hdrv_o),
    .ldrv_o      (ldrv_o)
  );

endmodule

// File: rtl/pwm_adaptive_dt_chk.sv
module pwm_adaptive_dt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic lg_low_i,
  input logic hdrv_o,
  input logic ldrv_o
);
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdrv_o && ldrv_o));

  // R10
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hdrv_o && !ldrv_o));

  // R6
  ls_after_hs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldrv_o) |-> $past(!hdrv_o));

  // R7
  hs_after_lg_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdrv_o) |-> ($past(lg_low_i) && $past(!ldrv_o)));

endmodule

bind pwm_adaptive_dt pwm_adaptive_dt_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .lg_low_i(lg_low_i),
  .hdrv_o  (hdrv_o),
  .ldrv_o  (ldrv_o)
);

// File: tb/pwm_adaptive_dt_test.sv
module pwm_adaptive_dt_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] fsel = 2'd0;
  logic [7:0] duty = 8'd0;
  logic [7:0] tmo = 8'd20;
  logic       sw_low = 1'b0;
  logic       lg_low = 1'b1;
  logic       hdrv, ldrv;

  always #10 clk = ~clk;  // 50 MHz

  pwm_adaptive_dt uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .freq_sel_i(fsel), .duty_i(duty),
    .sw_tmo_i(tmo), .sw_low_i(sw_low), .lg_low_i(lg_low), .hdrv_o(hdrv), .ldrv_o(ldrv)
  );

  int compared = 0, mismatched = 0, ncyc = 0, overlap = 0;
  string cur_req = "R1";
  int sw_dly = 1, sw_cnt = 0;
  bit sw_stuck = 0, lg_stuck = 0;

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, ncyc);
    end
  endtask

  // behavioural power stage: feedback flags follow the commands
  always @(negedge clk) begin
    ncyc++;
    if (hdrv && ldrv) overlap++;
    lg_low <= lg_stuck ? 1'b0 : !ldrv;
    if (hdrv) begin
      sw_cnt = 0;
      sw_low <= 1'b0;
    end else begin
      if (sw_cnt < 1000) sw_cnt++;
      sw_low <= !sw_stuck && (sw_cnt >= sw_dly);
    end
  end

  // reference model: 0 off, 1 hs, 2 wait sw, 3 ls, 4 wait lg
  int m_cnt, m_last, m_on, m_pwm, m_st, m_tmr;

  function automatic int per_of(int f);
    return (f == 0) ? 166 : (f == 1) ? 83 : 50;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int nst, p, lim, on;
    bit expd;
    if (!rst_n) begin
      m_cnt = 0; m_last = 165; m_on = 0; m_pwm = 0; m_st = 0; m_tmr = 0;
    end else begin
      expd = (m_tmr >= int'(tmo));
      nst = m_st;
      if (!en) nst = 0;
      else case (m_st)
        0: if (m_pwm && lg_low) nst = 1;
        1: if (!m_pwm) nst = 2;
        2: if (sw_low || expd) nst = 3;
        3: if (m_pwm) nst = 4;
        4: if (!m_pwm) nst = 3; else if (lg_low) nst = 1;
        default: nst = 0;
      endcase
      if (nst == 2 && m_st != 2) m_tmr = 1;
      else if (m_st == 2 && m_tmr < 255) m_tmr++;
      if (m_cnt == m_last) begin
        p = per_of(int'(fsel));
        lim = p - p / 20;
        on = (int'(duty) > lim) ? lim : int'(duty);
        m_cnt = 0; m_last = p - 1; m_on = on; m_pwm = (on != 0);
      end else begin
        m_cnt++;
        if (m_cnt == m_on) m_pwm = 0;
      end
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " hdrv"}, int'(hdrv), int'(m_st == 1));
      chk({cur_req, " ldrv"}, int'(ldrv), int'(m_st == 3));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_h_rise();
    logic p = hdrv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (hdrv && !p) break;
      p = hdrv;
    end
  endtask

  task automatic wait_h_fall();
    logic p = hdrv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!hdrv && p) break;
      p = hdrv;
    end
  endtask

  task automatic meas_period(output int per);
    int t0;
    wait_h_rise();
    t0 = ncyc;
    wait_h_rise();
    per = ncyc - t0;
  endtask

  task automatic meas_width(output int w);
    wait_h_rise();
    w = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!hdrv) break;
      w++;
    end
  endtask

  // clocks with both low between hdrv falling and ldrv rising
  task automatic meas_hl_gap(output int g);
    wait_h_fall();
    g = 0;
    for (int i = 0; i < 2000; i++) begin
      if (ldrv) break;
      g++;
      @(negedge clk);
    end
  endtask

  task automatic meas_lh_gap(output int g);
    logic p = ldrv;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!ldrv && p) break;
      p = ldrv;
    end
    g = 0;
    for (int i = 0; i < 2000; i++) begin
      if (hdrv) break;
      g++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int v, w1, w2, w3, hc, lc;
    cyc(2);
    chk("R1 reset hdrv", int'(hdrv), 0);
    chk("R1 reset ldrv", int'(ldrv), 0);
    cyc(3);
    rst_n = 1'b1;
    duty = 8'd100;
    cyc(40);
    chk("R1 disabled hdrv", int'(hdrv), 0);
    chk("R1 disabled ldrv", int'(ldrv), 0);

    // R10: enabled with zero duty, low side must stay off
    cur_req = "R10";
    duty = 8'd0;
    en = 1'b1;
    lc = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (ldrv) lc++; end
    chk("R10 no ls before first hs", lc, 0);

    cur_req = "R2";
    duty = 8'd60;
    cyc(400);
    meas_period(v); chk("R2 period sel0", v, 166);
    fsel = 2'd1; cyc(400);
    meas_period(v); chk("R2 period sel1", v, 83);
    fsel = 2'd2; cyc(300);
    meas_period(v); chk("R2 period sel2", v, 50);
    fsel = 2'd3; cyc(300);
    meas_period(v); chk("R2 period sel3", v, 50);

    cur_req = "R4";
    fsel = 2'd2;
    duty = 8'd255; cyc(150); meas_width(w1);
    duty = 8'd48;  cyc(150); meas_width(w2);
    chk("R4 clamp width", w1, w2);
    cur_req = "R3";
    duty = 8'd47;  cyc(150); meas_width(w3);
    chk("R3 width step", w3, w2 - 1);

    cur_req = "R6";
    duty = 8'd30;
    sw_dly = 1; cyc(150); meas_hl_gap(v); chk("R6 gap dly1", v, 1);
    sw_dly = 3; cyc(150); meas_hl_gap(v); chk("R6 gap dly3", v, 3);
    sw_dly = 1;
    cur_req = "R7";
    cyc(150); meas_lh_gap(v); chk("R7 gap", v, 1);

    cur_req = "R8";
    sw_stuck = 1;
    tmo = 8'd5; cyc(150); meas_hl_gap(v); chk("R8 timeout 5", v, 5);
    tmo = 8'd0; cyc(150); meas_hl_gap(v); chk("R8 timeout 0", v, 1);
    tmo = 8'd1; cyc(150); meas_hl_gap(v); chk("R8 timeout 1", v, 1);
    sw_stuck = 0; tmo = 8'd20;

    cur_req = "R11";
    cyc(100);
    lg_stuck = 1;
    cyc(60);
    hc = 0; lc = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (hdrv) hc++; if (ldrv) lc++; end
    chk("R11 hs skipped", hc, 0);
    chk("R11 ls resumes", int'(lc > 0), 1);
    lg_stuck = 0;

    cur_req = "R5";
    fsel = 2'd1; duty = 8'd0;
    cyc(250);
    hc = 0; lc = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (hdrv) hc++; if (!ldrv) lc++; end
    chk("R5 hs off", hc, 0);
    chk("R5 ls held", lc, 0);

    cur_req = "R10";
    duty = 8'd40; cyc(250);
    en = 1'b0;
    @(negedge clk);
    chk("R10 hdrv off", int'(hdrv), 0);
    chk("R10 ldrv off", int'(ldrv), 0);
    cyc(50);
    en = 1'b1;
    cur_req = "R3";
    cyc(400);

    chk("R9 overlap count", overlap, 0);
    summary();
    $finish;
  end

endmodule